// File: doc/BRIEF.md
# Bonded-Lane Transmit Deskew Aligner

This block lines up the parallel transmit words of several bonded lanes so that words belonging together leave on the same clock edge. The user logic raises a marker bit inside the parallel word on every bonded lane once per eight words. Each lane writes its words into a short elastic buffer. A lane whose marker reaches the buffer head before the other lanes' markers is held. The lanes that lag are drained until the markers of all lanes sit at their heads together. From then on all enabled lanes are read in lockstep.

Checking never stops. A running count of aligned marker sets rates how well the lanes are locked. A marker that reaches the heads of only some lanes, or a marker that arrives off its eight-word rhythm, drops every lane back to the misaligned grade. Each lane has a status byte on a small read port. The byte holds a two-bit progress grade and an aligned flag.

Top module: `tx_lane_deskew`

## Requirements
- R1: A word carries a marker when any of its marker bits is 1. With `DOUBLE_W=0` the marker bits are 33 and 113. With `DOUBLE_W=1` they are 33, 73, 113 and 153. All other bits, including 73 and 153 in single-width mode, do not affect alignment.
- R2: Each enabled lane owns an 8-entry FIFO. The FIFO is written on every cycle where the lane's `in_valid` is 1 and the FIFO is not full.
- R3: A lane whose FIFO head holds a marker is held while another enabled lane's head does not. During that time the non-marker heads of non-empty lanes are discarded. Otherwise, all enabled lanes are read together, but only when every enabled FIFO is non-empty. Each such read appears on `out_data` with `out_valid`=1 one cycle later. Lane k occupies bits [k*WORD_W +: WORD_W], so the marker words of all lanes leave in the same beat and lane-to-lane order is kept.
- R4: A lane with `lane_en`=0 is ignored. Its input is not written, it takes no part in alignment, its `out_data` slice is zero and its status byte reads 0.
- R5: The progress grade of a lane is 00 until a marker has reached that lane's FIFO head.
- R6: Once a marker has been seen, the grade is 01 whenever the aligned-set count is zero. This holds before the first aligned set and after any misalignment.
- R7: The grade is 10 after 1 to 15 aligned sets and 11 after 16 or more. The aligned flag is 1 exactly when the grade is 10 or 11.
- R8: A held-marker cycle clears the aligned-set count. So does an output beat without a marker eight beats after the last aligned marker, and so does an aligned marker at any other spacing. The next aligned set after a clear counts as one.
- R9: `reg_rd`=1 reads the status byte of lane `reg_addr`. The byte appears on `reg_rdata` on the next cycle, with the aligned flag at bit 4, the grade at bits 3:2 and the other bits at zero. An address of `LANES` or above reads 0. `reg_rdata` holds its value while `reg_rd`=0.
- R10: After reset, `out_valid`=0, `reg_rdata`=0 and every status byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_en | input | LANES | Per-lane bonding enable |
| in_valid | input | LANES | Per-lane input word strobe |
| in_data | input | LANES*WORD_W | Input words, lane k at [k*WORD_W +: WORD_W] |
| out_valid | output | 1 | Aligned output beat |
| out_data | output | LANES*WORD_W | Aligned words, lane k at [k*WORD_W +: WORD_W] |
| reg_rd | input | 1 | Status read strobe |
| reg_addr | input | ADDR_W | Lane index to read |
| reg_rdata | output | 8 | Status byte, one cycle after the strobe |

## Verification
The hardest state to reach is a loss of lock after full lock, followed by the count restarting at one. The bench reaches it two ways. First, it removes the word just before a marker from one lane only. That lane's marker then arrives one beat early and forces a held-marker cycle. Second, it suppresses the markers on all lanes for five periods so the rhythm check fires. It reads the status during each disturbance and after it. Skew between the lanes, marker bits placed on one position at a time, decoy bits 73 and 153, and a disabled lane that sends markers on every word all run during the same stream.

// File: rtl/tx_lane_deskew.sv
module tx_lane_deskew #(
  parameter int LANES       = 4,
  parameter int WORD_W      = 160,
  parameter bit DOUBLE_W    = 1'b0,
  parameter int FIFO_DEPTH  = 8,
  parameter int MARK_PERIOD = 8,
  parameter int LOCK_SETS   = 16,
  parameter int ADDR_W      = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES-1:0]          lane_en,
  input  logic [LANES-1:0]          in_valid,
  input  logic [LANES*WORD_W-1:0]   in_data,
  output logic                      out_valid,
  output logic [LANES*WORD_W-1:0]   out_data,
  input  logic                      reg_rd,
  input  logic [ADDR_W-1:0]         reg_addr,
  output logic [7:0]                reg_rdata
);
  localparam int PW = $clog2(FIFO_DEPTH);
  localparam int FW = $clog2(FIFO_DEPTH + 1);
  localparam int SW = $clog2(MARK_PERIOD);
  localparam int CW = $clog2(LOCK_SETS + 1);

  function automatic logic mark_of(input logic [WORD_W-1:0] w);
    if (DOUBLE_W) return w[33] | w[73] | w[113] | w[153];
    else          return w[33] | w[113];
  endfunction

  logic [LANES-1:0][WORD_W-1:0] head, out_q;
  logic [LANES-1:0] avail, head_mk, pop, seen, out_mk;
  logic [CW-1:0] sets;
  logic [SW-1:0] sp;

  wire any_en  = |lane_en;
  wire all_mk  = any_en && (head_mk == lane_en);
  wire partial = (|head_mk) && !all_mk;
  wire all_av  = any_en && ((lane_en & ~avail) == '0);
  wire beat    = all_av && !partial;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WORD_W-1:0] mem [FIFO_DEPTH];
    logic [PW-1:0] wp, rp;
    logic [FW-1:0] fill;
    logic seen_q;
    wire wr = in_valid[g] & lane_en[g] & (fill != FW'(FIFO_DEPTH));

    always_ff @(posedge clk)
      if (wr) mem[wp] <= in_data[g*WORD_W +: WORD_W];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp <= '0; rp <= '0; fill <= '0; seen_q <= 1'b0;
      end else begin
        if (wr)     wp <= (wp == PW'(FIFO_DEPTH-1)) ? '0 : wp + 1'b1;
        if (pop[g]) rp <= (rp == PW'(FIFO_DEPTH-1)) ? '0 : rp + 1'b1;
        fill <= fill + FW'(wr) - FW'(pop[g]);
        if (head_mk[g]) seen_q <= 1'b1;
      end
    end

    assign avail[g]   = (fill != '0);
    assign head[g]    = mem[rp];
    assign head_mk[g] = avail[g] & lane_en[g] & mark_of(mem[rp]);
    assign pop[g]     = lane_en[g] & avail[g] & (partial ? ~head_mk[g] : beat);
    assign seen[g]    = seen_q;
    assign out_mk[g]  = mark_of(out_q[g]);
    assign out_data[g*WORD_W +: WORD_W] = out_q[g];

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FW'(FIFO_DEPTH)); // R2
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (partial && head_mk[g]) |=> $stable(rp)); // R3
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_q     <= '0;
    end else begin
      out_valid <= beat;
      if (beat)
        for (int l = 0; l < LANES; l++) out_q[l] <= lane_en[l] ? head[l] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sets <= '0; sp <= '0;
    end else if (partial) begin
      sets <= '0; sp <= '0;
    end else if (beat) begin
      if (all_mk) begin
        if (sets == '0)                          sets <= CW'(1);
        else if (sp == SW'(MARK_PERIOD-1))       sets <= (sets == CW'(LOCK_SETS)) ? sets : sets + 1'b1;
        else                                     sets <= '0;
        sp <= '0;
      end else if (sp == SW'(MARK_PERIOD-1)) begin
        sets <= '0; sp <= '0;
      end else begin
        sp <= sp + 1'b1;
      end
    end
  end

  logic [7:0] sel;
  always_comb begin
    sel = '0;
    for (int l = 0; l < LANES; l++) begin
      logic [1:0] code;
      if (!lane_en[l] || !seen[l])        code = 2'b00;
      else if (sets == '0)                code = 2'b01;
      else if (sets >= CW'(LOCK_SETS))    code = 2'b11;
      else                                code = 2'b10;
      if (reg_addr == ADDR_W'(l)) sel = {3'b000, code[1], code, 2'b00};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= sel;
  end

  AST_MARK_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ((out_mk & lane_en) != '0)) |-> ((out_mk & lane_en) == lane_en)); // R3
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_rd) |-> $stable(reg_rdata)); // R9
  AST_SETS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sets != $past(sets)) |-> (sets == '0 || sets == $past(sets) + 1'b1)); // R8
  AST_PARTIAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    partial |=> (sets == '0)); // R8
endmodule

// File: tb/tx_lane_deskew_tb.sv
module tx_lane_deskew_tb_top;
  localparam int L = 4, W = 160, TOTAL = 700;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [L-1:0] lane_en = 4'b0111, in_valid = '0;
  logic [L*W-1:0] in_data = '0, out_data;
  logic out_valid, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_rdata;
  int vectors = 0, fails = 0, beats = 0, skipped = 0;
  int ns [L] = '{0, 0, 0, 0};
  bit start = 0, done = 0;
  int q [$];

  always #2 clk = ~clk;

  tx_lane_deskew dut_i (.clk(clk), .rst_n(rst_n), .lane_en(lane_en), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata));

  function automatic bit has_mark(int s);
    return (s % 8 == 0) && !(s >= 400 && s < 440);
  endfunction

  function automatic logic [W-1:0] mkw(int l, int s);
    logic [W-1:0] w = '0;
    w[15:0] = 16'(s); w[23:16] = 8'(l);
    if (has_mark(s)) begin
      if (s % 16 == 0) w[33] = 1'b1; else w[113] = 1'b1;   // R1 one position at a time
    end
    if (s % 8 == 3) w[73] = 1'b1;                          // R1 decoys in single width
    if (s % 8 == 5) w[153] = 1'b1;
    return w;
  endfunction

  task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; reg_addr = a + 4'd1;
    chk(W'(reg_rdata), W'(exp), tag);
    @(negedge clk);
    chk(W'(reg_rdata), W'(exp), {tag, " R9 hold"});
  endtask

  // driver: lane streams with skew, a dropped word on lane 2, a disabled lane 3
  initial begin
    int skew [L] = '{0, 3, 4, 1};
    wait (start);
    for (int t = 0; t < TOTAL + 20; t++) begin
      @(negedge clk);
      for (int l = 0; l < L; l++) begin
        in_valid[l] = 1'b0;
        if (t >= skew[l] && ns[l] < TOTAL) begin
          if (l == 2 && ns[l] == 255) ns[l]++;
          in_valid[l] = 1'b1;
          if (l == 3) begin
            in_data[l*W +: W] = mkw(l, ns[l]);
            in_data[l*W + 33] = 1'b1;
          end else in_data[l*W +: W] = mkw(l, ns[l]);
          if (l == 0) q.push_back(ns[0]);
          ns[l]++;
        end
      end
    end
    @(negedge clk); in_valid = '0;
    done = 1;
  end

  // monitor: scoreboard of lane-0 sequence numbers
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      int s;
      s = int'(out_data[15:0]);
      beats++;
      while (q.size() > 0 && q[0] != s) begin void'(q.pop_front()); skipped++; end
      if (q.size() == 0) begin
        fails++; vectors++;
        $display("FAIL R3 unexpected seq act=%0d exp=queued", s);
      end else begin
        void'(q.pop_front());
        for (int l = 0; l < 3; l++) chk(out_data[l*W +: W], mkw(l, s), "R3 lane word");
        chk(out_data[3*W +: W], '0, "R4 disabled lane slice");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(W'(out_valid), W'(0), "R10 out_valid in reset");
    chk(W'(reg_rdata), W'(0), "R10 rdata in reset");
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) rd(4'(a), 8'h00, "R5 R10 status after reset");
    start = 1;
    wait (ns[0] >= 200);
    rd(4'd0, 8'h1C, "R7 lane0 locked");
    rd(4'd1, 8'h1C, "R7 lane1 locked");
    rd(4'd2, 8'h1C, "R7 lane2 locked");
    rd(4'd3, 8'h00, "R4 disabled lane status");
    rd(4'd5, 8'h00, "R9 out of range address");
    wait (ns[0] >= 300);
    rd(4'd0, 8'h18, "R8 count restarted after drop");
    rd(4'd2, 8'h18, "R8 dropped lane restarted");
    wait (ns[0] >= 420);
    rd(4'd1, 8'h04, "R6 missing markers");
    wait (ns[0] >= 470);
    rd(4'd1, 8'h18, "R8 one aligned set after resume");
    wait (ns[0] >= 680);
    rd(4'd0, 8'h1C, "R7 relocked");
    wait (done);
    repeat (30) @(negedge clk);
    chk(W'(beats), W'(TOTAL - 1), "R3 aligned beat count");
    chk(W'(skipped), W'(1), "R3 discarded words");
    chk(W'(out_valid), W'(0), "R2 stream drained");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule